// File: doc/BRIEF.md
# Keyed Two-Write Gate Reset Sequencer

This block keeps a bank of semaphore lock gates. Each gate holds a small code that says which bus master owns it, and zero means unlocked. Software that needs to break a lock left by a stuck master cannot just write the gate. Instead it writes a keyed pair of values to one reset register. The first value arms the sequencer. The second, from the same master, names one gate or all gates to be cleared.

The block sits on a plain 16-bit register bus: an address, a write strobe, write data, the ID of the master making the access, and combinational read data. Any write that does not continue the pair correctly sends the sequencer back to idle. A status word can be read at the reset register. It gives the sequencer state, the master that took part in the sequence, and the gate selector last used for a clear. A small load path lets a gate's owner code be written directly. The gate values also leave the block on a flat output bus.

Top module: `gate_reset_seq`

## Requirements
- R1: After reset the status word reads 0x0000 and every gate holds zero.
- R2: A write to the reset register (offset 0x100) whose upper byte is 0xE2 moves the sequencer to armed (state code 1) when it is idle or done. The lower byte of that write is ignored, and the status master field takes the writer's ID.
- R3: While the sequencer is armed, a write to the reset register with upper byte 0x1D from the master that armed it moves the sequencer to done (state code 2). The status gate field then holds that write's lower byte, and the selected gates read zero in the next cycle.
- R4: In the completing write, a lower byte of 0–15 clears only that gate. A lower byte of 64 or more clears every gate. A lower byte of 16–63 clears no gate.
- R5: While the sequencer is armed, any other write to the reset register sends it to idle without changing any gate or the status gate field. This covers a wrong upper byte, a write from a different master, and a repeated 0xE2.
- R6: The done state lasts one cycle and then returns to idle, unless a write to the reset register in that cycle is handled as it would be from idle.
- R7: Cycles with no write, including reads of the status word, change no state. Writes to gate load addresses leave the sequencer state unchanged, apart from the step from done to idle.
- R8: The status word read at offset 0x100 puts the state in bits 13:12 (idle 0, armed 1, done 2), the master ID in bits 10:8 and the gate field in bits 7:0. All other bits read zero, and state code 3 never appears.
- R9: A write to address n, for n in 0–15, loads gate n with write-data bits 3:0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 9 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_mid | input | 3 | ID of the accessing master |
| bus_rdata | output | 16 | Read data: status word at 0x100, a gate value at 0–15, zero elsewhere |
| gate_owner_o | output | 64 | Gate values, 4 bits per gate, gate 0 in the low bits |

## Verification
The hardest situations to reach are those where the armed state meets a write it must not accept. One case is a write from another master carrying the correct second key. Another is a write that arrives in the single done cycle, right behind a completed clear. Directed sequences set each of these up, with gates preloaded to non-zero values so that a wrong clear shows on the outputs. Random traffic then mixes gate loads, both keys and arbitrary data from random masters. It often reuses the arming master's ID, so that completions and breaks happen with about the same frequency.

// File: rtl/gr_pkg.sv
package gr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DONE  = 2'd2
    } seq_st_e;

    localparam logic [7:0] KEY_FIRST  = 8'hE2;
    localparam logic [7:0] KEY_SECOND = ~KEY_FIRST;
endpackage

// File: rtl/gr_key_fsm.sv
module gr_key_fsm
    import gr_pkg::*;
#(
    parameter int MID_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [7:0]       key_i,
    input  logic [7:0]       sel_i,
    input  logic [MID_W-1:0] mid_i,
    output seq_st_e          st_o,
    output logic [MID_W-1:0] mid_o,
    output logic [7:0]       last_o,
    output logic             fire_o,
    output logic [7:0]       fire_sel_o
);
    typedef struct packed {
        seq_st_e          st;
        logic [MID_W-1:0] mid;
        logic [7:0]       last;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic fire_d;

    always_comb begin
        fsm_d  = fsm_q;
        fire_d = 1'b0;
        if (fsm_q.st == ST_DONE) begin
            fsm_d.st = ST_IDLE;
        end
        if (hit_i) begin
            if (fsm_q.st == ST_ARMED) begin
                if (key_i == KEY_SECOND && mid_i == fsm_q.mid) begin
                    fsm_d.st   = ST_DONE;
                    fsm_d.last = sel_i;
                    fire_d     = 1'b1;
                end else begin
                    fsm_d.st = ST_IDLE;
                end
            end else if (key_i == KEY_FIRST) begin
                fsm_d.st  = ST_ARMED;
                fsm_d.mid = mid_i;
            end else begin
                fsm_d.st = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, mid: '0, last: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign st_o       = fsm_q.st;
    assign mid_o      = fsm_q.mid;
    assign last_o     = fsm_q.last;
    assign fire_o     = fire_d;
    assign fire_sel_o = sel_i;
endmodule

// File: rtl/gr_gate_bank.sv
module gr_gate_bank #(
    parameter int N_GATES = 16,
    parameter int GATE_W  = 4,
    parameter int ALL_MIN = 64,
    localparam int IDX_W  = $clog2(N_GATES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en_i,
    input  logic [IDX_W-1:0]          load_idx_i,
    input  logic [GATE_W-1:0]         load_val_i,
    input  logic                      fire_i,
    input  logic [7:0]                fire_sel_i,
    output logic [N_GATES*GATE_W-1:0] gates_o
);
    logic clr_all;
    assign clr_all = (fire_sel_i >= 8'(ALL_MIN));

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        logic [GATE_W-1:0] gate_d, gate_q;

        always_comb begin
            gate_d = gate_q;
            if (load_en_i && load_idx_i == IDX_W'(g)) begin
                gate_d = load_val_i;
            end
            if (fire_i && (clr_all || fire_sel_i == 8'(g))) begin
                gate_d = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gate_q <= '0;
            end else begin
                gate_q <= gate_d;
            end
        end

        assign gates_o[g*GATE_W +: GATE_W] = gate_q;
    end
endmodule

// File: rtl/gr_status.sv
module gr_status #(
    parameter int N_GATES  = 16,
    parameter int GATE_W   = 4,
    parameter int MID_W    = 3,
    parameter int ADDR_W   = 9,
    parameter int RST_OFS  = 256,
    localparam int IDX_W   = $clog2(N_GATES)
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [1:0]                st_i,
    input  logic [MID_W-1:0]          mid_i,
    input  logic [7:0]                last_i,
    input  logic [N_GATES*GATE_W-1:0] gates_i,
    output logic [15:0]               rdata_o
);
    logic [IDX_W-1:0] idx;
    assign idx = addr_i[IDX_W-1:0];

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(RST_OFS)) begin
            rdata_o[13:12]        = st_i;
            rdata_o[8 +: MID_W]   = mid_i;
            rdata_o[7:0]          = last_i;
        end else if (addr_i < ADDR_W'(N_GATES)) begin
            rdata_o[GATE_W-1:0] = gates_i[idx*GATE_W +: GATE_W];
        end
    end
endmodule

// File: rtl/gate_reset_seq.sv
module gate_reset_seq
    import gr_pkg::*;
#(
    parameter int N_GATES = 16,
    parameter int GATE_W  = 4,
    parameter int MID_W   = 3,
    parameter int ADDR_W  = 9,
    parameter int RST_OFS = 256,
    parameter int ALL_MIN = 64,
    localparam int IDX_W  = $clog2(N_GATES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [15:0]               bus_wdata,
    input  logic [MID_W-1:0]          bus_mid,
    output logic [15:0]               bus_rdata,
    output logic [N_GATES*GATE_W-1:0] gate_owner_o
);
    logic             hit_rst;
    logic             load_en;
    seq_st_e          seq_st;
    logic [1:0]       seq_state;
    logic [MID_W-1:0] seq_mid;
    logic [7:0]       seq_last;
    logic             fire;
    logic [7:0]       fire_sel;

    assign hit_rst   = bus_we && (bus_addr == ADDR_W'(RST_OFS));
    assign load_en   = bus_we && (bus_addr < ADDR_W'(N_GATES));
    assign seq_state = 2'(seq_st);

    gr_key_fsm #(.MID_W(MID_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit_rst),
        .key_i     (bus_wdata[15:8]),
        .sel_i     (bus_wdata[7:0]),
        .mid_i     (bus_mid),
        .st_o      (seq_st),
        .mid_o     (seq_mid),
        .last_o    (seq_last),
        .fire_o    (fire),
        .fire_sel_o(fire_sel)
    );

    gr_gate_bank #(
        .N_GATES(N_GATES), .GATE_W(GATE_W), .ALL_MIN(ALL_MIN)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en_i (load_en),
        .load_idx_i(bus_addr[IDX_W-1:0]),
        .load_val_i(bus_wdata[GATE_W-1:0]),
        .fire_i    (fire),
        .fire_sel_i(fire_sel),
        .gates_o   (gate_owner_o)
    );

    gr_status #(
        .N_GATES(N_GATES), .GATE_W(GATE_W), .MID_W(MID_W),
        .ADDR_W(ADDR_W), .RST_OFS(RST_OFS)
    ) u_status (
        .addr_i (bus_addr),
        .st_i   (seq_state),
        .mid_i  (seq_mid),
        .last_i (seq_last),
        .gates_i(gate_owner_o),
        .rdata_o(bus_rdata)
    );
endmodule

// File: rtl/gate_reset_seq_chk.sv
module gate_reset_seq_chk #(
    parameter int N_GATES = 16,
    parameter int GATE_W  = 4,
    parameter int MID_W   = 3,
    parameter int ADDR_W  = 9,
    parameter int RST_OFS = 256,
    parameter int ALL_MIN = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic                      we,
    input logic [15:0]               wdata,
    input logic [MID_W-1:0]          mid,
    input logic [1:0]                st,
    input logic [MID_W-1:0]          mst,
    input logic [7:0]                last,
    input logic [N_GATES*GATE_W-1:0] gates
);
    logic hit;
    logic good2;
    assign hit   = we && (addr == ADDR_W'(RST_OFS));
    assign good2 = hit && st == 2'd1 && wdata[15:8] == 8'h1D && mid == mst;

    a_r8_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st != 2'd3);

    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st != 2'd1 && wdata[15:8] == 8'hE2)
        |=> (st == 2'd1 && mst == $past(mid)));

    a_r3_complete: assert property (@(posedge clk) disable iff (!rst_n)
        good2 |=> (st == 2'd2 && last == $past(wdata[7:0])));

    a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (good2 && wdata[7:0] >= 8'(ALL_MIN)) |=> (gates == '0));

    a_r5_break: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st == 2'd1 && !good2)
        |=> (st == 2'd0 && $stable(gates) && $stable(last)));

    a_r6_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'd2 && !hit) |=> (st == 2'd0));

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && st != 2'd2)
        |=> ($stable(st) && $stable(gates) && $stable(mst) && $stable(last)));
endmodule

bind gate_reset_seq gate_reset_seq_chk #(
    .N_GATES(N_GATES), .GATE_W(GATE_W), .MID_W(MID_W),
    .ADDR_W(ADDR_W), .RST_OFS(RST_OFS), .ALL_MIN(ALL_MIN)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .addr (bus_addr),
    .we   (bus_we),
    .wdata(bus_wdata),
    .mid  (bus_mid),
    .st   (seq_state),
    .mst  (seq_mid),
    .last (seq_last),
    .gates(gate_owner_o)
);

// File: tb/gate_reset_seq_bench.sv
`timescale 1ns/1ps
module gate_reset_seq_bench;
    localparam logic [8:0] RST_A = 9'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [2:0]  bus_mid = '0;
    logic [15:0] bus_rdata;
    logic [63:0] gate_owner_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0] m_g [16];
    logic [1:0] m_st;
    logic [2:0] m_mst;
    logic [7:0] m_last;

    always #10 clk = ~clk;

    gate_reset_seq u_gate_reset_seq (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_mid(bus_mid), .bus_rdata(bus_rdata),
        .gate_owner_o(gate_owner_o)
    );

    function automatic logic [15:0] exp_status();
        return {2'b00, m_st, 1'b0, m_mst, m_last};
    endfunction

    function automatic logic [63:0] exp_gates();
        logic [63:0] v;
        for (int g = 0; g < 16; g++) v[g*4 +: 4] = m_g[g];
        return v;
    endfunction

    task automatic model_step(input bit we, input logic [8:0] a,
                              input logic [15:0] d, input logic [2:0] m);
        logic [1:0] prev;
        prev = m_st;
        if (m_st == 2'd2) m_st = 2'd0;
        if (we && a == RST_A) begin
            if (prev == 2'd1) begin
                if (d[15:8] == 8'h1D && m == m_mst) begin
                    m_st = 2'd2;
                    m_last = d[7:0];
                    for (int g = 0; g < 16; g++)
                        if (d[7:0] >= 8'd64 || d[7:0] == 8'(g)) m_g[g] = 4'd0;
                end else begin
                    m_st = 2'd0;
                end
            end else if (d[15:8] == 8'hE2) begin
                m_st = 2'd1;
                m_mst = m;
            end else begin
                m_st = 2'd0;
            end
        end else if (we && a < 9'd16) begin
            m_g[a[3:0]] = d[3:0];
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d, input logic [2:0] m);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d; bus_mid = m;
        @(posedge clk);
        model_step(1'b1, a, d, m);
    endtask

    task automatic chk(input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = RST_A; bus_wdata = $urandom; bus_mid = $urandom;
        #1;
        checks++;
        if (bus_rdata !== exp_status()) begin
            failures++;
            $display("FAIL %s status actual=%h expected=%h", tag, bus_rdata, exp_status());
        end
        checks++;
        if (gate_owner_o !== exp_gates()) begin
            failures++;
            $display("FAIL %s gates actual=%h expected=%h", tag, gate_owner_o, exp_gates());
        end
        @(posedge clk);
        model_step(1'b0, RST_A, 16'h0, 3'd0);
    endtask

    task automatic preload(input int salt);
        for (int g = 0; g < 16; g++) wr(9'(g), 16'((g + salt) % 15 + 1), 3'(g));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int g = 0; g < 16; g++) m_g[g] = '0;
        m_st = '0; m_mst = '0; m_last = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk("R1 reset");

        preload(0);
        chk("R9 gate load");

        wr(RST_A, 16'hE25A, 3'd3);
        chk("R2 arm");
        wr(RST_A, 16'h1D05, 3'd3);
        chk("R3 done single gate 5");
        chk("R6 done to idle");

        wr(RST_A, 16'hE2FF, 3'd2);
        chk("R7 read armed");
        chk("R7 read armed again");
        wr(9'd1, 16'h0006, 3'd4);
        chk("R7 load keeps armed");
        wr(RST_A, 16'h1D40, 3'd2);
        chk("R4 clear all 0x40");

        preload(3);
        wr(RST_A, 16'hE200, 3'd1);
        wr(RST_A, 16'h1D02, 3'd6);
        chk("R5 other master breaks");
        wr(RST_A, 16'hE200, 3'd1);
        wr(RST_A, 16'h1E03, 3'd1);
        chk("R5 wrong pattern breaks");
        wr(RST_A, 16'hE200, 3'd5);
        wr(RST_A, 16'hE200, 3'd5);
        chk("R5 repeated first key breaks");

        wr(RST_A, 16'hE211, 3'd0);
        wr(RST_A, 16'h1D20, 3'd0);
        chk("R4 selector 0x20 clears none");
        wr(RST_A, 16'hE211, 3'd7);
        wr(RST_A, 16'h1D0F, 3'd7);
        chk("R4 single gate 15");
        wr(RST_A, 16'hE200, 3'd4);
        wr(RST_A, 16'h1DFF, 3'd4);
        wr(RST_A, 16'hE233, 3'd6);
        chk("R6 write in done cycle arms");
        wr(RST_A, 16'h1D3F, 3'd6);
        chk("R4 selector 63 clears none");

        preload(7);
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [15:0] d;
            logic [2:0] m;
            op = $urandom % 8;
            m = ($urandom % 2 == 0) ? m_mst : 3'($urandom);
            case (op)
                0, 1: wr(9'($urandom % 16), 16'($urandom), 3'($urandom));
                2, 3: wr(RST_A, {8'hE2, 8'($urandom)}, m);
                4, 5: begin
                    case ($urandom % 3)
                        0: d = {8'h1D, 8'($urandom % 16)};
                        1: d = {8'h1D, 8'(64 + $urandom % 192)};
                        default: d = {8'h1D, 8'($urandom)};
                    endcase
                    wr(RST_A, d, m);
                end
                6: wr(RST_A, 16'($urandom), m);
                default: ;
            endcase
            if ($urandom % 3 != 0) chk("R8 random mix");
        end
        chk("R8 final");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule